// File: doc/BRIEF.md
# Compressed Control-Transfer Resolver

This block resolves the destination of the five 16-bit control-transfer instructions: the unconditional relative jump, the register jump with and without a link, and the two compare-with-zero branches. Each instruction enters with its program counter on a valid/ready input channel. The block presents a register read index on the same cycle and takes the read value back from the surrounding register file. One cycle after acceptance, a result channel carries the next program counter, an optional link write and a fail flag.

Selection is by encoding. Quadrant `01` (bits 1:0) with bits 15:13 equal to `101` is the relative jump, `110` is branch-if-zero and `111` is branch-if-nonzero. Quadrant `10` with bits 6:2 zero and bits 15:12 equal to `1000` is the register jump. With bits 15:12 equal to `1001` it is the linking register jump. Any other encoding is reported as a failure.

The input side accepts a transfer when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. A result stays on the output channel, unchanged, until `out_ready` is seen high while `out_valid` is high. The register read is combinational: `rd_idx` follows `in_insn`, and `rd_val` must answer in the same cycle.

Top module: `cxfer_unit`

## Requirements
- R1: A transfer accepted at a clock edge appears on the output channel after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R2: For the relative jump, the byte offset is gathered as follows: bit 12 gives offset bit 11, bit 8 gives bit 10, bits 10:9 give bits 9:8, bit 6 gives bit 7, bit 7 gives bit 6, bit 2 gives bit 5, bit 11 gives bit 4 and bits 5:3 give bits 3:1. Offset bit 0 is zero. The offset is sign-extended from bit 11, and the next PC is pc plus the offset.
- R3: For the register jump, `rd_idx` is bits 11:7, the next PC is `rd_val`, and no write is requested.
- R4: For the linking register jump, the next PC is `rd_val`, and a write of pc+2 to register 1 is requested.
- R5: A register jump of either kind with bits 11:7 equal to zero raises `out_fail` and requests no write.
- R6: For both branches, `rd_idx` is 8 plus bits 9:7.
- R7: The branch offset is gathered as follows: bit 12 gives offset bit 8, bits 6:5 give bits 7:6, bit 2 gives bit 5, bits 11:10 give bits 4:3 and bits 4:3 give bits 2:1. The offset is sign-extended from bit 8. Branch-if-zero is taken when `rd_val` is zero, and branch-if-nonzero when it is not. A taken branch goes to pc plus the offset.
- R8: A branch that is not taken goes to pc+2.
- R9: Every encoding not listed above raises `out_fail`, requests no write, and returns the next PC equal to pc.
- R10: `out_wr_en` is high only for a valid linking register jump, and then `out_wr_idx` is 1. Address arithmetic wraps modulo 2^XLEN.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_insn | input | 16 | Compressed instruction |
| in_pc | input | XLEN | Address of the instruction |
| rd_idx | output | 5 | Register read index, decoded from `in_insn` |
| rd_val | input | XLEN | Register value for `rd_idx`, same cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | XLEN | Resolved next program counter |
| out_wr_en | output | 1 | Link write requested |
| out_wr_idx | output | 5 | Link write register index |
| out_wr_data | output | XLEN | Link write value |
| out_fail | output | 1 | Instruction could not be resolved |

## Verification
The assertions assume that `rd_val` is a settled function of `rd_idx` within the cycle of acceptance. They also assume that `in_insn` and `in_pc` do not change between the falling edge that drives them and the next rising edge. The bench keeps to both. A behavioural register file inside the bench answers `rd_idx` combinationally. Every input, including `out_ready`, is driven only on falling edges. Branch source registers are preloaded with a mix of zero and nonzero values, so that both outcomes of each branch occur. Instructions are built by scattering chosen offsets into the encodings, and the expected next PC is derived from the chosen offset.

// File: rtl/cxfer_pkg.sv
`timescale 1ns/1ps
package cxfer_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_J    = 3'd1,
    OP_JR   = 3'd2,
    OP_JALR = 3'd3,
    OP_BEQZ = 3'd4,
    OP_BNEZ = 3'd5
  } xfer_op_e;

  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned STEP_BYTES = 2;
  localparam logic [REG_IDX_W-1:0] LINK_REG = 5'd1;

  localparam logic [1:0] QUAD_ONE  = 2'b01;
  localparam logic [1:0] QUAD_TWO  = 2'b10;
  localparam logic [2:0] F3_JUMP   = 3'b101;
  localparam logic [2:0] F3_BRZ    = 3'b110;
  localparam logic [2:0] F3_BRNZ   = 3'b111;
  localparam logic [2:0] F3_REGJMP = 3'b100;

endpackage

// File: rtl/cxfer_decode.sv
`timescale 1ns/1ps
module cxfer_decode
  import cxfer_pkg::*;
(
  input  logic [15:0]          insn,
  output xfer_op_e             op,
  output logic [REG_IDX_W-1:0] src_idx,
  output logic                 src_zero
);

  logic [1:0] quad;
  logic [2:0] f3;
  logic [4:0] rs_field;
  logic [4:0] low_field;

  assign quad      = insn[1:0];
  assign f3        = insn[15:13];
  assign rs_field  = insn[11:7];
  assign low_field = insn[6:2];
  assign src_zero  = (rs_field == '0);

  always_comb begin
    op      = OP_NONE;
    src_idx = '0;
    case (quad)
      QUAD_ONE: begin
        case (f3)
          F3_JUMP: op = OP_J;
          F3_BRZ: begin
            op      = OP_BEQZ;
            src_idx = {2'b01, insn[9:7]};
          end
          F3_BRNZ: begin
            op      = OP_BNEZ;
            src_idx = {2'b01, insn[9:7]};
          end
          default: op = OP_NONE;
        endcase
      end
      QUAD_TWO: begin
        if (f3 == F3_REGJMP && low_field == '0) begin
          src_idx = rs_field;
          op      = insn[12] ? OP_JALR : OP_JR;
        end
      end
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/cxfer_offset.sv
`timescale 1ns/1ps
module cxfer_offset #(
  parameter int unsigned XLEN = 32
) (
  input  logic [12:2]     field,
  output logic [XLEN-1:0] jump_off,
  output logic [XLEN-1:0] branch_off
);

  localparam int unsigned J_W = 12;
  localparam int unsigned B_W = 9;

  logic [J_W-1:0] j_raw;
  logic [B_W-1:0] b_raw;

  always_comb begin
    j_raw      = '0;
    j_raw[11]  = field[12];
    j_raw[10]  = field[8];
    j_raw[9:8] = field[10:9];
    j_raw[7]   = field[6];
    j_raw[6]   = field[7];
    j_raw[5]   = field[2];
    j_raw[4]   = field[11];
    j_raw[3:1] = field[5:3];
  end

  always_comb begin
    b_raw      = '0;
    b_raw[8]   = field[12];
    b_raw[7:6] = field[6:5];
    b_raw[5]   = field[2];
    b_raw[4:3] = field[11:10];
    b_raw[2:1] = field[4:3];
  end

  assign jump_off   = {{(XLEN-J_W){j_raw[J_W-1]}}, j_raw};
  assign branch_off = {{(XLEN-B_W){b_raw[B_W-1]}}, b_raw};

endmodule

// File: rtl/cxfer_resolve.sv
`timescale 1ns/1ps
module cxfer_resolve
  import cxfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  xfer_op_e        op,
  input  logic            src_zero,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] reg_val,
  input  logic [XLEN-1:0] jump_off,
  input  logic [XLEN-1:0] branch_off,
  output logic [XLEN-1:0] next_pc,
  output logic            wr_en,
  output logic [XLEN-1:0] wr_data,
  output logic            fail
);

  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  logic [XLEN-1:0] seq_pc;
  logic            val_zero;

  assign seq_pc   = pc + STEP;
  assign val_zero = (reg_val == '0);
  assign wr_data  = seq_pc;

  always_comb begin
    next_pc = pc;
    wr_en   = 1'b0;
    fail    = 1'b0;
    case (op)
      OP_J:    next_pc = pc + jump_off;
      OP_JR: begin
        if (src_zero) fail = 1'b1;
        else          next_pc = reg_val;
      end
      OP_JALR: begin
        if (src_zero) begin
          fail = 1'b1;
        end else begin
          next_pc = reg_val;
          wr_en   = 1'b1;
        end
      end
      OP_BEQZ: next_pc = val_zero  ? pc + branch_off : seq_pc;
      OP_BNEZ: next_pc = !val_zero ? pc + branch_off : seq_pc;
      default: fail = 1'b1;
    endcase
  end

endmodule

// File: rtl/cxfer_unit.sv
`timescale 1ns/1ps
module cxfer_unit
  import cxfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [15:0]          in_insn,
  input  logic [XLEN-1:0]      in_pc,
  output logic [REG_IDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]      rd_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      out_next_pc,
  output logic                 out_wr_en,
  output logic [REG_IDX_W-1:0] out_wr_idx,
  output logic [XLEN-1:0]      out_wr_data,
  output logic                 out_fail
);

  xfer_op_e        op;
  logic            src_zero;
  logic [XLEN-1:0] jump_off;
  logic [XLEN-1:0] branch_off;
  logic [XLEN-1:0] nxt_pc;
  logic            nxt_wen;
  logic [XLEN-1:0] nxt_wdata;
  logic            nxt_fail;
  logic            take;

  cxfer_decode u_decode (
    .insn     (in_insn),
    .op       (op),
    .src_idx  (rd_idx),
    .src_zero (src_zero)
  );

  cxfer_offset #(.XLEN(XLEN)) u_offset (
    .field      (in_insn[12:2]),
    .jump_off   (jump_off),
    .branch_off (branch_off)
  );

  cxfer_resolve #(.XLEN(XLEN)) u_resolve (
    .op         (op),
    .src_zero   (src_zero),
    .pc         (in_pc),
    .reg_val    (rd_val),
    .jump_off   (jump_off),
    .branch_off (branch_off),
    .next_pc    (nxt_pc),
    .wr_en      (nxt_wen),
    .wr_data    (nxt_wdata),
    .fail       (nxt_fail)
  );

  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready;
  assign out_wr_idx = LINK_REG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_next_pc <= '0;
      out_wr_en   <= 1'b0;
      out_wr_data <= '0;
      out_fail    <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_next_pc <= nxt_pc;
        out_wr_en   <= nxt_wen;
        out_wr_data <= nxt_wdata;
        out_fail    <= nxt_fail;
      end
    end
  end

endmodule

// File: rtl/cxfer_unit_chk.sv
`timescale 1ns/1ps
module cxfer_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [15:0]     in_insn,
  input logic [XLEN-1:0] in_pc,
  input logic [4:0]      rd_idx,
  input logic [XLEN-1:0] rd_val,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_wr_en,
  input logic [XLEN-1:0] out_wr_data,
  input logic            out_fail
);

  logic acc;
  logic is_brz;
  logic is_br;
  logic is_regjmp;
  logic is_link;

  assign acc       = in_valid && in_ready;
  assign is_br     = (in_insn[1:0] == 2'b01) && (in_insn[15:14] == 2'b11);
  assign is_brz    = is_br && !in_insn[13];
  assign is_regjmp = (in_insn[1:0] == 2'b10) && (in_insn[15:13] == 3'b100) && (in_insn[6:2] == 5'd0);
  assign is_link   = is_regjmp && in_insn[12];

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) && $stable(out_fail)
                                   && $stable(out_wr_en) && $stable(out_wr_data)));

  assert_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_link && in_insn[11:7] != 5'd0) |=>
      (out_wr_en && out_wr_data == $past(in_pc) + XLEN'(2) && out_next_pc == $past(rd_val)));

  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_regjmp && in_insn[11:7] == 5'd0) |=> (out_fail && !out_wr_en));

  assert_br_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_br |-> (rd_idx == {2'b01, in_insn[9:7]}));

  assert_fallthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_brz && rd_val != '0) |=> (out_next_pc == $past(in_pc) + XLEN'(2)));

  assert_wen_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr_en) |-> !out_fail);

endmodule

bind cxfer_unit cxfer_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_insn     (in_insn),
  .in_pc       (in_pc),
  .rd_idx      (rd_idx),
  .rd_val      (rd_val),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_next_pc (out_next_pc),
  .out_wr_en   (out_wr_en),
  .out_wr_data (out_wr_data),
  .out_fail    (out_fail)
);

// File: tb/test_cxfer_unit.sv
`timescale 1ns/1ps
module test_cxfer_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [15:0]     in_insn;
  logic [XLEN-1:0] in_pc;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_val;
  logic            out_valid;
  logic            out_ready;
  logic [XLEN-1:0] out_next_pc;
  logic            out_wr_en;
  logic [4:0]      out_wr_idx;
  logic [XLEN-1:0] out_wr_data;
  logic            out_fail;

  always #2.5 clk = ~clk;

  cxfer_unit #(.XLEN(XLEN)) i_cxfer_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_pc(in_pc), .rd_idx(rd_idx), .rd_val(rd_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data),
    .out_fail(out_fail)
  );

  logic [XLEN-1:0] regs [32];
  always_comb rd_val = regs[rd_idx];

  typedef struct {
    logic [15:0] insn;
    logic [31:0] pc;
    logic [31:0] e_pc;
    logic        e_wen;
    logic [31:0] e_wd;
    logic        e_fail;
    logic        idx_chk;
    logic [4:0]  e_idx;
    string       tag;
  } item_t;

  item_t pend[$];
  item_t expq[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_cj(input logic [31:0] o);
    logic [15:0] w;
    w = 16'h0001;
    w[15:13] = 3'b101;
    w[12] = o[11]; w[11] = o[4]; w[10:9] = o[9:8]; w[8] = o[10];
    w[7] = o[6]; w[6] = o[7]; w[5:3] = o[3:1]; w[2] = o[5];
    return w;
  endfunction

  function automatic logic [15:0] enc_br(input bit nz, input logic [2:0] rsp, input logic [31:0] o);
    logic [15:0] w;
    w = 16'h0001;
    w[15:13] = nz ? 3'b111 : 3'b110;
    w[12] = o[8]; w[11:10] = o[4:3]; w[9:7] = rsp;
    w[6:5] = o[7:6]; w[4:3] = o[2:1]; w[2] = o[5];
    return w;
  endfunction

  function automatic item_t mk(input logic [15:0] insn, input logic [31:0] pc, input string tag);
    item_t it;
    it.insn = insn; it.pc = pc; it.tag = tag;
    it.e_pc = pc; it.e_wen = 1'b0; it.e_wd = pc + 32'd2; it.e_fail = 1'b0;
    it.idx_chk = 1'b0; it.e_idx = 5'd0;
    return it;
  endfunction

  task automatic add_cj(input int off, input logic [31:0] pc);
    item_t it;
    it = mk(enc_cj(32'(off)), pc, "R2");
    it.e_pc = pc + 32'(off);
    pend.push_back(it);
  endtask

  task automatic add_br(input bit nz, input int rsp, input int off, input logic [31:0] pc);
    item_t it;
    bit taken;
    logic [31:0] v;
    v = regs[8 + rsp];
    taken = nz ? (v != 0) : (v == 0);
    it = mk(enc_br(nz, 3'(rsp), 32'(off)), pc, taken ? "R7" : "R8");
    it.e_pc = taken ? pc + 32'(off) : pc + 32'd2;
    it.idx_chk = 1'b1;
    it.e_idx = 5'(8 + rsp);
    pend.push_back(it);
  endtask

  task automatic add_jr(input bit link, input int rs, input logic [31:0] pc);
    item_t it;
    logic [15:0] w;
    w = {3'b100, link, 5'(rs), 5'd0, 2'b10};
    it = mk(w, pc, (rs == 0) ? "R5" : (link ? "R4" : "R3"));
    it.idx_chk = 1'b1;
    it.e_idx = 5'(rs);
    if (rs == 0) it.e_fail = 1'b1;
    else begin
      it.e_pc = regs[rs];
      it.e_wen = link;
    end
    pend.push_back(it);
  endtask

  task automatic add_bad(input logic [15:0] w, input logic [31:0] pc);
    item_t it;
    it = mk(w, pc, "R9");
    it.e_fail = 1'b1;
    pend.push_back(it);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=drained");
    finish_run();
  end

  initial begin
    bit stalled;
    logic [31:0] held_pc;
    logic held_fail;
    for (int i = 0; i < 32; i++) regs[i] = 32'h2000_0000 + 32'(i) * 32'h0001_0104;
    regs[0] = 32'h0; regs[8] = 32'h0; regs[12] = 32'h0; regs[11] = 32'hFFFF_FFFF;
    regs[5] = 32'h1234_5679;
    rst_n = 1'b0; in_valid = 1'b0; in_insn = 16'h0; in_pc = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R11", "in_ready in reset", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'h0);

    add_cj(0, 32'h8000_0100);
    add_cj(2, 32'h8000_0100);
    add_cj(-2, 32'h8000_0100);
    add_cj(2046, 32'h0000_1000);
    add_cj(-2048, 32'h0000_1000);
    add_cj(-2, 32'h0000_0000);
    add_cj(32'h2AA, 32'h4000_0000);
    add_cj(-32'h556, 32'h4000_0000);
    for (int k = 0; k < 8; k++) add_cj(int'($urandom_range(0, 4095)) - 2048 & ~1, 32'h8000_0000 + ($urandom & 32'hFFFE));
    for (int r = 0; r < 8; r++) begin
      add_br(1'b0, r, 254, 32'h9000_0000);
      add_br(1'b1, r, -256, 32'h9000_0000);
      add_br(1'b0, r, (int'($urandom_range(0, 511)) - 256) & ~1, 32'h9000_2000);
      add_br(1'b1, r, (int'($urandom_range(0, 511)) - 256) & ~1, 32'h9000_2000);
    end
    add_jr(1'b0, 1, 32'h100);
    add_jr(1'b0, 5, 32'h100);
    add_jr(1'b0, 31, 32'h104);
    add_jr(1'b1, 5, 32'h200);
    add_jr(1'b1, 1, 32'h202);
    add_jr(1'b1, 17, 32'hFFFF_FFFE);
    add_jr(1'b0, 0, 32'h300);
    add_jr(1'b1, 0, 32'h302);
    add_bad(16'h0000, 32'h400);
    add_bad(16'h4501, 32'h404);
    add_bad(16'h8506, 32'h408);
    add_bad(16'hFFFF, 32'h40C);
    add_bad(16'h8001 | 16'h0100, 32'h410);
    add_bad(16'hA002, 32'h414);
    add_bad(16'h9006, 32'h418);

    stalled = 1'b0; held_pc = '0; held_fail = 1'b0;
    while (pend.size() > 0 || expq.size() > 0) begin
      @(negedge clk);
      if (pend.size() > 0 && ($urandom % 5) != 0) begin
        in_valid = 1'b1;
        in_insn = pend[0].insn;
        in_pc = pend[0].pc;
      end else begin
        in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (stalled) begin
        chk(out_valid == 1'b1, "R1", "held valid", 32'(out_valid), 32'h1);
        chk(out_next_pc == held_pc && out_fail == held_fail, "R1", "held result", out_next_pc, held_pc);
      end
      chk(in_ready == (!out_valid || out_ready), "R1", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R1", "unexpected output", 32'h1, 32'h0);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(out_fail == e.e_fail, e.tag, "fail", 32'(out_fail), 32'(e.e_fail));
          chk(out_next_pc == e.e_pc, e.tag, "next_pc", out_next_pc, e.e_pc);
          chk(out_wr_en == e.e_wen, e.e_wen ? "R4" : "R10", "wr_en", 32'(out_wr_en), 32'(e.e_wen));
          if (e.e_wen) begin
            chk(out_wr_data == e.e_wd, "R4", "wr_data", out_wr_data, e.e_wd);
            chk(out_wr_idx == 5'd1, "R10", "wr_idx", 32'(out_wr_idx), 32'h1);
          end
        end
      end
      stalled = out_valid && !out_ready;
      held_pc = out_next_pc;
      held_fail = out_fail;
      if (in_valid && pend[0].idx_chk)
        chk(rd_idx == pend[0].e_idx, (pend[0].e_idx >= 5'd8 && pend[0].insn[1:0] == 2'b01) ? "R6" : "R3",
            "rd_idx", 32'(rd_idx), 32'(pend[0].e_idx));
      if (in_valid && in_ready) expq.push_back(pend.pop_front());
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "drained", 32'(out_valid), 32'h0);
    finish_run();
  end

endmodule